// File: doc/BRIEF.md
# Multi-Cycle Step Controller

This block is the sequencing controller of a processor that spends several clock cycles on each instruction. A single state register walks through an instruction fetch step and a register read step that every instruction shares, and then through an execution path chosen by the operation code held in the instruction register. Every datapath control line is a function of the current step alone, so the lines change only at clock edges and stay stable for the whole cycle.

The datapath around it holds the program counter, instruction register, operand registers, ALU output register and memory data register. Each cycle the controller picks the memory address source, enables memory reads and writes, selects the ALU operands and operation class, loads the instruction register or the program counter, and writes the register file. Five instruction classes are handled: load word, store word, register-to-register ALU operations, branch-if-equal and jump. When an instruction finishes, the controller goes back to the fetch step.

Top module: `mc_step_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller in the fetch step. From the cycle after that edge, and for as long as `rst` stays high, the outputs show the fetch encoding. After release the next step is decode.
- R2: The fetch step drives mem_rd=1, ir_load=1, pc_load=1, addr_sel_data=0, alu_a_sel=0, alu_b_sel=01, alu_mode=00 and pc_src=00, and always moves to decode.
- R3: The decode step drives alu_a_sel=0, alu_b_sel=11 and alu_mode=00. It dispatches on `opcode`: 100011 (load) and 101011 (store) go to address calculation, 000000 (register ALU) goes to ALU execute, 000100 (branch-if-equal) goes to branch, and 000010 (jump) goes to jump.
- R4: The address calculation step drives alu_a_sel=1, alu_b_sel=10 and alu_mode=00. With opcode 100011 it moves to memory read. With any other opcode it moves to memory write.
- R5: The memory read step drives mem_rd=1 and addr_sel_data=1, then moves to load write-back. Load write-back drives rf_we=1, dst_sel_rd=0 and wb_sel_mem=1.
- R6: The memory write step drives mem_wr=1 and addr_sel_data=1.
- R7: The ALU execute step drives alu_a_sel=1, alu_b_sel=00 and alu_mode=10, then moves to ALU write-back. ALU write-back drives rf_we=1, dst_sel_rd=1 and wb_sel_mem=0.
- R8: The branch step drives alu_a_sel=1, alu_b_sel=00, alu_mode=01, pc_load_if_eq=1 and pc_src=01.
- R9: The jump step drives pc_load=1 and pc_src=10.
- R10: Every output that a step does not list is 0, and in no step are mem_rd and mem_wr both high. `opcode` is ignored in every step except decode and address calculation.
- R11: When decode sees an opcode outside the five listed codes, the next step is fetch.
- R12: Load write-back, memory write, ALU write-back, branch and jump each return to fetch. An instruction therefore takes 5 cycles for a load, 4 for a store or register ALU operation, and 3 for a branch or jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Operation code field from the instruction register |
| addr_sel_data | output | 1 | Memory address from ALU output register (1) or program counter (0) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU output register (0) |
| ir_load | output | 1 | Instruction register load enable |
| pc_load | output | 1 | Unconditional program counter load |
| pc_load_if_eq | output | 1 | Program counter load when the ALU zero flag is set |
| pc_src | output | 2 | Program counter source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 per function field |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted extended immediate |
| dst_sel_rd | output | 1 | Register destination field: 1 rd, 0 rt |
| rf_we | output | 1 | Register file write enable |

## Verification
The main stimulus is a stream of instructions: each of the five classes alone, then back to back in mixed orders, then two undefined opcodes. These show that each dispatch leads to the right step path, with the right encoding in every step and the right number of cycles. A second pattern puts misleading opcodes (the load code, the store code, undefined values) on the input during the steps that must ignore it. This separates a correct controller from one that dispatches in the wrong step. A reset raised during an ALU operation shows that reset works in the middle of a path and not only from idle.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    // Step numbering. The bench and the documentation refer to these values.
    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_REXE   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BEQ    = 4'd8,
        ST_JMP    = 4'd9
    } step_e;

    // Positions of the instruction classes in the match vector
    localparam int CL_RTYPE = 0;
    localparam int CL_LOAD  = 1;
    localparam int CL_STORE = 2;
    localparam int CL_BEQ   = 3;
    localparam int CL_JUMP  = 4;
    localparam int N_CLASS  = 5;

    // Datapath control bundle produced in every step
    typedef struct packed {
        logic       addr_sel_data;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_sel_mem;
        logic       ir_load;
        logic       pc_load;
        logic       pc_load_if_eq;
        logic [1:0] pc_src;
        logic [1:0] alu_mode;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       dst_sel_rd;
        logic       rf_we;
    } ctrl_t;

    // Sequencer state register contents
    typedef struct packed {
        step_e step;
    } seq_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify #(
    parameter int                OP_W     = 6,
    parameter logic [OP_W-1:0]   OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0]   OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0]   OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0]   OP_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0]   OP_JUMP  = 6'b000010
) (
    input  logic [OP_W-1:0]                  opcode,
    output logic [mc_ctrl_pkg::N_CLASS-1:0]  cls_hit
);
    import mc_ctrl_pkg::*;

    // Code table, with entry index equal to the class position
    localparam logic [N_CLASS*OP_W-1:0] CODE_TAB = {OP_JUMP, OP_BEQ, OP_STORE, OP_LOAD, OP_RTYPE};

    for (genvar g = 0; g < N_CLASS; g++) begin : g_match
        assign cls_hit[g] = (opcode == CODE_TAB[g*OP_W +: OP_W]);
    end

endmodule

// File: rtl/mc_next_step.sv
module mc_next_step (
    input  mc_ctrl_pkg::step_e               cur,
    input  logic [mc_ctrl_pkg::N_CLASS-1:0]  cls_hit,
    output mc_ctrl_pkg::step_e               nxt
);
    import mc_ctrl_pkg::*;

    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (cls_hit[CL_LOAD] || cls_hit[CL_STORE]) nxt = ST_ADDR;
                else if (cls_hit[CL_RTYPE])                nxt = ST_REXE;
                else if (cls_hit[CL_BEQ])                  nxt = ST_BEQ;
                else if (cls_hit[CL_JUMP])                 nxt = ST_JMP;
                else                                       nxt = ST_FETCH;
            end
            ST_ADDR:   nxt = cls_hit[CL_LOAD] ? ST_LDRD : ST_STWR;
            ST_LDRD:   nxt = ST_LDWB;
            ST_REXE:   nxt = ST_RWB;
            // Every terminal step, and any unused code, goes back to fetch
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_step_decode.sv
module mc_step_decode (
    input  mc_ctrl_pkg::step_e  cur,
    output mc_ctrl_pkg::ctrl_t  ctl
);
    import mc_ctrl_pkg::*;

    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.pc_load   = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b11;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_we      = 1'b1;
                ctl.wb_sel_mem = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_sel_data = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_mode  = 2'b10;
            end
            ST_RWB: begin
                ctl.rf_we      = 1'b1;
                ctl.dst_sel_rd = 1'b1;
            end
            ST_BEQ: begin
                ctl.alu_a_sel     = 1'b1;
                ctl.alu_mode      = 2'b01;
                ctl.pc_load_if_eq = 1'b1;
                ctl.pc_src        = 2'b01;
            end
            ST_JMP: begin
                ctl.pc_load = 1'b1;
                ctl.pc_src  = 2'b10;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_step_ctrl.sv
module mc_step_ctrl #(
    parameter int                OP_W     = 6,
    parameter logic [OP_W-1:0]   OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0]   OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0]   OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0]   OP_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0]   OP_JUMP  = 6'b000010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            addr_sel_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            wb_sel_mem,
    output logic            ir_load,
    output logic            pc_load,
    output logic            pc_load_if_eq,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_mode,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            dst_sel_rd,
    output logic            rf_we
);
    import mc_ctrl_pkg::*;

    seq_t                 seq_d, seq_q;
    logic [N_CLASS-1:0]   cls_hit;
    step_e                nxt_step;
    ctrl_t                ctl;

    mc_op_classify #(
        .OP_W     (OP_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) i_classify (
        .opcode  (opcode),
        .cls_hit (cls_hit)
    );

    mc_next_step i_next (
        .cur     (seq_q.step),
        .cls_hit (cls_hit),
        .nxt     (nxt_step)
    );

    mc_step_decode i_decode (
        .cur (seq_q.step),
        .ctl (ctl)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.step = nxt_step;
        if (rst) begin
            seq_d.step = ST_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    // Moore outputs: a function of the registered step only
    assign addr_sel_data = ctl.addr_sel_data;
    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign wb_sel_mem    = ctl.wb_sel_mem;
    assign ir_load       = ctl.ir_load;
    assign pc_load       = ctl.pc_load;
    assign pc_load_if_eq = ctl.pc_load_if_eq;
    assign pc_src        = ctl.pc_src;
    assign alu_mode      = ctl.alu_mode;
    assign alu_a_sel     = ctl.alu_a_sel;
    assign alu_b_sel     = ctl.alu_b_sel;
    assign dst_sel_rd    = ctl.dst_sel_rd;
    assign rf_we         = ctl.rf_we;

endmodule

// File: rtl/mc_step_ctrl_chk.sv
module mc_step_ctrl_chk #(
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic            addr_sel_data,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            wb_sel_mem,
    input logic            ir_load,
    input logic            pc_load,
    input logic            pc_load_if_eq,
    input logic [1:0]      alu_b_sel,
    input logic            alu_a_sel,
    input logic            dst_sel_rd,
    input logic            rf_we
);
    logic in_decode, in_addr, op_known;
    assign in_decode = (alu_b_sel == 2'b11) && !alu_a_sel;
    assign in_addr   = (alu_b_sel == 2'b10) && alu_a_sel;
    assign op_known  = (opcode == OP_RTYPE) || (opcode == OP_LOAD) || (opcode == OP_STORE)
                    || (opcode == OP_BEQ) || (opcode == OP_JUMP);

    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_load && mem_rd && pc_load));

    p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (alu_b_sel == 2'b11 && !ir_load));

    p_load_path_r4: assert property (@(posedge clk) disable iff (rst)
        (in_addr && opcode == OP_LOAD) |=> (mem_rd && addr_sel_data));

    p_store_path_r4: assert property (@(posedge clk) disable iff (rst)
        (in_addr && opcode != OP_LOAD) |=> (mem_wr && addr_sel_data));

    p_read_to_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel_data) |=> (rf_we && wb_sel_mem && !dst_sel_rd));

    p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_unknown_refetch_r11: assert property (@(posedge clk) disable iff (rst)
        (in_decode && !op_known) |=> ir_load);

    p_done_to_fetch_r12: assert property (@(posedge clk) disable iff (rst)
        (rf_we || mem_wr || pc_load_if_eq || (pc_load && !ir_load)) |=> ir_load);

endmodule

bind mc_step_ctrl mc_step_ctrl_chk #(
    .OP_W     (OP_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_BEQ   (OP_BEQ),
    .OP_JUMP  (OP_JUMP)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .opcode        (opcode),
    .addr_sel_data (addr_sel_data),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .wb_sel_mem    (wb_sel_mem),
    .ir_load       (ir_load),
    .pc_load       (pc_load),
    .pc_load_if_eq (pc_load_if_eq),
    .alu_b_sel     (alu_b_sel),
    .alu_a_sel     (alu_a_sel),
    .dst_sel_rd    (dst_sel_rd),
    .rf_we         (rf_we)
);

// File: tb/test_mc_step_ctrl.sv
module test_mc_step_ctrl;

    localparam logic [5:0] OPR = 6'b000000;
    localparam logic [5:0] OPL = 6'b100011;
    localparam logic [5:0] OPS = 6'b101011;
    localparam logic [5:0] OPB = 6'b000100;
    localparam logic [5:0] OPJ = 6'b000010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       addr_sel_data, mem_rd, mem_wr, wb_sel_mem, ir_load, pc_load, pc_load_if_eq;
    logic [1:0] pc_src, alu_mode, alu_b_sel;
    logic       alu_a_sel, dst_sel_rd, rf_we;

    always #5 clk = ~clk;

    mc_step_ctrl i_mc_step_ctrl (
        .clk (clk), .rst (rst), .opcode (opcode),
        .addr_sel_data (addr_sel_data), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .wb_sel_mem (wb_sel_mem), .ir_load (ir_load), .pc_load (pc_load),
        .pc_load_if_eq (pc_load_if_eq), .pc_src (pc_src), .alu_mode (alu_mode),
        .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel), .dst_sel_rd (dst_sel_rd),
        .rf_we (rf_we)
    );

    typedef struct {
        logic [5:0] op;
        int         st;
        int         len;
        string      tag;
        string      ltag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    int    since_fetch = 0;
    int    last_len = 0;
    string last_ltag = "R12";
    bit    seen_fetch = 1'b0;

    wire [15:0] act = {addr_sel_data, mem_rd, mem_wr, wb_sel_mem, ir_load, pc_load,
                       pc_load_if_eq, pc_src, alu_mode, alu_a_sel, alu_b_sel, dst_sel_rd, rf_we};

    // Expected encoding per step, taken from the requirements
    function automatic logic [15:0] exp_vec(int st);
        logic a_d = 0, rd = 0, wr = 0, wbm = 0, ir = 0, pcl = 0, pce = 0, asel = 0, dst = 0, we = 0;
        logic [1:0] psrc = 0, mode = 0, bsel = 0;
        case (st)
            0: begin rd = 1; ir = 1; pcl = 1; bsel = 2'b01; end
            1: bsel = 2'b11;
            2: begin asel = 1; bsel = 2'b10; end
            3: begin rd = 1; a_d = 1; end
            4: begin we = 1; wbm = 1; end
            5: begin wr = 1; a_d = 1; end
            6: begin asel = 1; mode = 2'b10; end
            7: begin we = 1; dst = 1; end
            8: begin asel = 1; mode = 2'b01; pce = 1; psrc = 2'b01; end
            9: begin pcl = 1; psrc = 2'b10; end
            default: ;
        endcase
        return {a_d, rd, wr, wbm, ir, pcl, pce, psrc, mode, asel, bsel, dst, we};
    endfunction

    function automatic string req_of(int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_vec(string r, logic [15:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: outputs %h expected %h at %0t", r, act, e, $time);
        end
    endtask

    task automatic push(logic [5:0] op, int st, int len, string tag, string ltag);
        item_t it;
        it.op = op; it.st = st; it.len = len; it.tag = tag; it.ltag = ltag;
        sbq.push_back(it);
    endtask

    // Driver: expected step sequence for one instruction. junk is driven in
    // steps where the opcode must be ignored (R10).
    task automatic drive_instr(logic [5:0] op, logic [5:0] junk);
        string jt = (junk != op) ? "R10" : "";
        case (op)
            OPL: begin
                push(junk, 0, 5, jt == "" ? "R2" : jt, "R12");
                push(op, 1, 0, "R3", "");
                push(op, 2, 0, "R4", "");
                push(junk, 3, 0, jt == "" ? "R5" : jt, "");
                push(junk, 4, 0, jt == "" ? "R5" : jt, "");
            end
            OPS: begin
                push(junk, 0, 4, jt == "" ? "R2" : jt, "R12");
                push(op, 1, 0, "R3", "");
                push(op, 2, 0, "R4", "");
                push(junk, 5, 0, jt == "" ? "R6" : jt, "");
            end
            OPR: begin
                push(junk, 0, 4, jt == "" ? "R2" : jt, "R12");
                push(op, 1, 0, "R3", "");
                push(junk, 6, 0, jt == "" ? "R7" : jt, "");
                push(junk, 7, 0, jt == "" ? "R7" : jt, "");
            end
            OPB: begin
                push(junk, 0, 3, jt == "" ? "R2" : jt, "R12");
                push(op, 1, 0, "R3", "");
                push(junk, 8, 0, jt == "" ? "R8" : jt, "");
            end
            OPJ: begin
                push(junk, 0, 3, jt == "" ? "R2" : jt, "R12");
                push(op, 1, 0, "R3", "");
                push(junk, 9, 0, jt == "" ? "R9" : jt, "");
            end
            default: begin
                push(junk, 0, 2, "R2", "R11");
                push(op, 1, 0, "R11", "");
            end
        endcase
    endtask

    // Monitor: one item per cycle, compared at the falling edge
    task automatic run_scoreboard();
        while (sbq.size() > 0) begin
            item_t it = sbq.pop_front();
            if (it.st == 0) begin
                if (seen_fetch) begin
                    checks++;
                    if (since_fetch != last_len) begin
                        errors++;
                        $display("FAIL %s: instruction length %0d expected %0d", last_ltag, since_fetch, last_len);
                    end
                end
                seen_fetch  = 1'b1;
                since_fetch = 0;
                last_len    = it.len;
                last_ltag   = it.ltag;
            end
            check_vec(it.tag == "" ? req_of(it.st) : it.tag, exp_vec(it.st));
            since_fetch++;
            opcode = it.op;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_vec("R1", exp_vec(0));

        // Each class alone, ideal opcode
        drive_instr(OPL, OPL);
        drive_instr(OPS, OPS);
        drive_instr(OPR, OPR);
        drive_instr(OPB, OPB);
        drive_instr(OPJ, OPJ);
        // Misleading opcodes outside the dispatch steps (R10)
        drive_instr(OPR, OPL);
        drive_instr(OPB, OPS);
        drive_instr(OPJ, OPR);
        drive_instr(OPL, 6'h3f);
        drive_instr(OPS, OPL);
        // Undefined opcodes at decode (R11)
        drive_instr(6'h3f, 6'h3f);
        drive_instr(6'b001000, OPL);
        // Mixed back-to-back stream
        drive_instr(OPL, OPB);
        drive_instr(OPL, OPJ);
        drive_instr(OPJ, OPJ);
        drive_instr(OPR, OPS);
        drive_instr(OPB, OPB);

        rst = 1'b0;
        run_scoreboard();

        // Length of the final instruction, then a reset in mid-path
        checks++;
        if (since_fetch != last_len) begin
            errors++;
            $display("FAIL %s: instruction length %0d expected %0d", last_ltag, since_fetch, last_len);
        end
        check_vec("R12", exp_vec(0));
        opcode = OPR;
        @(negedge clk);
        check_vec("R3", exp_vec(1));
        @(negedge clk);
        check_vec("R7", exp_vec(6));
        rst = 1'b1;
        @(negedge clk);
        check_vec("R1", exp_vec(0));
        @(negedge clk);
        check_vec("R1", exp_vec(0));
        rst = 1'b0;
        @(negedge clk);
        check_vec("R1", exp_vec(1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule